// File: doc/BRIEF.md
# Power Button Event Controller

This block turns presses of an active-low power button into status flags and interrupt requests for system firmware. The button input is synchronised, and the falling edge of the synchronised copy counts as one press. Holding the button down yields no further events, and releasing it yields none at all.

In normal mode a press sets the ordinary button flag. That flag drives the SCI output while its enable bit is set. In fast-resume mode a press sets a separate fast-resume flag instead, and a control bit sends that flag to either the SMI or the SCI output. While the enable bit is set in fast-resume mode, the ordinary flag stays clear. An SMI handler can then pass control to the SCI handler by writing an "SCI now" command. Later, an SCI handler can inject the ordinary flag by writing a second command.

Firmware reaches the block through a single-cycle register write port and a combinational read port. Status flags are cleared by writing 1 to them.

Top module: `pwr_evt_ctrl`

## Requirements
- R1: After reset the control register and all status flags read 0, and `smi_o` and `sci_o` are low.
- R2: A press is a high-to-low transition of the synchronised button input. Holding the input low gives exactly one event, and a low-to-high transition gives none.
- R3: With the mode bit clear, a press sets the ordinary flag (status bit 0). `sci_o` is high while that flag is set and the enable bit (control bit 1) is set.
- R4: With the mode bit (control bit 0) set, a press sets the fast-resume flag (status bit 1). It also sets the ordinary flag only when the enable bit is clear.
- R5: With the mode bit set, the fast-resume flag drives `smi_o` when the route bit (control bit 2) is 1, and drives `sci_o` when it is 0. With the mode bit clear, the fast-resume flag drives neither output.
- R6: Writing 1 to command bit 0 (address 2) sets the SCI-now flag (status bit 2), which holds `sci_o` high.
- R7: Writing 1 to command bit 1 (address 2) sets the ordinary flag.
- R8: Writing 1 to a bit at the status address (1) clears that flag. A press in the same cycle takes priority, so the flag ends up set.
- R9: The control register (address 0) reads back its 3 written bits. The command address always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrbtn_ni | input | 1 | Power button, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 command |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| smi_o | output | 1 | SMI request, level |
| sci_o | output | 1 | SCI request, level |

## Verification
Two events can land on the same status flag in the same clock: a detected press, and a write-1-to-clear from firmware. To provoke this, the bench pulls the button low and then waits exactly the synchroniser latency. It issues the clear so that the clear arrives on the edge where the falling-edge pulse is present. The flag must then read 1, and the interrupt level must stay as the enable bits dictate. The same collision is also applied to the fast-resume flag, and it arises by chance in the randomised sequence.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STS  = 2'd1,
    REG_CMD  = 2'd2
  } reg_addr_e;

  localparam int unsigned CTRL_W = 3;
  localparam int unsigned STS_W  = 3;

  typedef struct packed {
    logic smi_route;  // bit 2
    logic pb_en;      // bit 1
    logic mode_en;    // bit 0
  } ctrl_t;

  typedef struct packed {
    logic now;        // bit 2
    logic fr;         // bit 1
    logic pb;         // bit 0
  } sts_t;

  localparam int unsigned CMD_NOW = 0;
  localparam int unsigned CMD_INJ = 1;
endpackage

// File: rtl/pwr_evt_edge.sv
module pwr_evt_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic press_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b1;
          else         chain_q[i] <= btn_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b1;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign press_o = chain_q[STAGES] & ~chain_q[STAGES-1];

  AST_ONE_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o); // R2
endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
  import pwr_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              press_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output sts_t              sts_o
);
  ctrl_t ctrl_q;
  sts_t  sts_q;
  logic  wr_ctrl, wr_sts, wr_cmd;
  logic  now_cmd, inj_cmd;
  sts_t  clr, set;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_sts  = wr_en_i && (addr_i == REG_STS);
  assign wr_cmd  = wr_en_i && (addr_i == REG_CMD);
  assign now_cmd = wr_cmd && wdata_i[CMD_NOW];
  assign inj_cmd = wr_cmd && wdata_i[CMD_INJ];

  always_comb begin
    clr = wr_sts ? sts_t'(wdata_i[STS_W-1:0]) : '0;
    set.fr  = press_i && ctrl_q.mode_en;
    // enable bit in fast-resume mode keeps the ordinary flag out of the press path
    set.pb  = (press_i && !(ctrl_q.mode_en && ctrl_q.pb_en)) || inj_cmd;
    set.now = now_cmd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sts_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      sts_q <= set | (sts_q & ~clr);  // set wins over clear
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_STS:  rdata_o[STS_W-1:0]  = sts_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign sts_o  = sts_q;

  AST_NORMAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && !ctrl_q.mode_en |=> sts_q.pb); // R3
  AST_FR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && ctrl_q.mode_en |=> sts_q.fr); // R4
  AST_PB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && ctrl_q.mode_en && ctrl_q.pb_en && !sts_q.pb && !wr_cmd |=> !sts_q.pb); // R4
  AST_NOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_cmd |=> sts_q.now); // R6
  AST_INJ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_cmd |=> sts_q.pb); // R7
endmodule

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrbtn_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              smi_o,
  output logic              sci_o
);
  logic  press;
  ctrl_t ctrl;
  sts_t  sts;

  pwr_evt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .btn_ni  (pwrbtn_ni),
    .press_o (press)
  );

  pwr_evt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .press_i (press),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .sts_o   (sts)
  );

  logic fr_live;
  assign fr_live = sts.fr && ctrl.mode_en;
  assign smi_o   = fr_live && ctrl.smi_route;
  assign sci_o   = (sts.pb && ctrl.pb_en) || (fr_live && !ctrl.smi_route) || sts.now;

  AST_NO_DUAL_FR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_o && !sts.fr)); // R5
  AST_NOW_HOLDS_SCI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts.now |-> sci_o); // R6
endmodule

// File: tb/tb_pwr_evt_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_evt_ctrl;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic smi, sci;
  int n_vec = 0, n_bad = 0;
  logic [2:0] m_ctrl = '0, m_sts = '0;

  always #2 clk = ~clk;

  pwr_evt_ctrl #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwrbtn_ni(btn_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .smi_o(smi), .sci_o(sci)
  );

  function automatic logic exp_smi(logic [2:0] c, logic [2:0] s);
    return s[1] & c[0] & c[2];
  endfunction
  function automatic logic exp_sci(logic [2:0] c, logic [2:0] s);
    return (s[0] & c[1]) | (s[1] & c[0] & ~c[2]) | s[2];
  endfunction

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; wr_en = 1'b0; #1 d = rdata;
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] d;
    rd(2'd0, d); cmp(tag, "ctrl", d, {5'b0, m_ctrl});
    rd(2'd1, d); cmp(tag, "status", d, {5'b0, m_sts});
    rd(2'd2, d); cmp(tag, "cmd readback (R9)", d, '0);
    cmp(tag, "smi_o", {7'b0, smi}, {7'b0, exp_smi(m_ctrl, m_sts)});
    cmp(tag, "sci_o", {7'b0, sci}, {7'b0, exp_sci(m_ctrl, m_sts)});
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      2'd0: m_ctrl = d[2:0];
      2'd1: m_sts  = m_sts & ~d[2:0];
      2'd2: begin
        if (d[0]) m_sts[2] = 1'b1;
        if (d[1]) m_sts[0] = 1'b1;
      end
      default: ;
    endcase
  endtask

  function automatic void model_press();
    if (m_ctrl[0]) m_sts[1] = 1'b1;
    if (!(m_ctrl[0] && m_ctrl[1])) m_sts[0] = 1'b1;
  endfunction

  task automatic set_btn(logic lvl);
    @(negedge clk);
    if (btn_n && !lvl) model_press();
    btn_n = lvl;
    repeat (4) @(negedge clk);
  endtask

  // press edge reaches the flags on the same edge as a W1C write
  task automatic collide(logic [2:0] clr);
    @(negedge clk); btn_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = 2'd1; wdata = {5'b0, clr}; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    m_sts = m_sts & ~clr;
    model_press();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1");

    // normal mode
    set_btn(1'b0); check_all("R3");
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h07); repeat (6) @(negedge clk); check_all("R2 held low");
    set_btn(1'b1); check_all("R2 release");
    wr(2'd0, 8'h02); set_btn(1'b0); check_all("R3 enabled");
    set_btn(1'b1); wr(2'd1, 8'h07);

    // fast-resume, enable set, route to SMI
    wr(2'd0, 8'h07); check_all("R9");
    set_btn(1'b0); check_all("R4");
    check_all("R5 smi");
    wr(2'd0, 8'h03); check_all("R5 sci");
    wr(2'd0, 8'h02); check_all("R5 mode off");
    set_btn(1'b1); wr(2'd1, 8'h07);

    // fast-resume, enable clear
    wr(2'd0, 8'h01); set_btn(1'b0); check_all("R4 both");
    set_btn(1'b1); wr(2'd1, 8'h07);

    // commands
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h01); check_all("R6");
    wr(2'd2, 8'h02); check_all("R7");
    wr(2'd1, 8'h07); check_all("R8");

    // same-cycle press and clear
    wr(2'd0, 8'h02); set_btn(1'b1);
    wr(2'd2, 8'h02);
    collide(3'b001); check_all("R8 collide pb");
    set_btn(1'b1);
    wr(2'd0, 8'h05); wr(2'd1, 8'h07);
    wr(2'd2, 8'h01);
    collide(3'b111); check_all("R8 collide fr");
    set_btn(1'b1);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin wr(2'd0, DW'($urandom % 8)); check_all("R9 rand"); end
        1: begin wr(2'd1, DW'($urandom % 8)); check_all("R8 rand"); end
        2: begin wr(2'd2, DW'($urandom % 4)); check_all("R6 rand"); end
        default: begin
          set_btn(~btn_n);
          check_all(m_ctrl[0] ? "R4 rand" : "R3 rand");
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule